// File: doc/BRIEF.md
# Decade Up/Down Counter Digit with Separate Count Inputs

This block holds one decimal digit, 0 to 9, and changes it on rising edges of two independent count inputs. A rising edge on the up input adds one and a rising edge on the down input subtracts one. At the ends of the range the digit wraps around. Both count inputs are treated as asynchronous: each passes through a flip-flop synchronizer on the system clock, and rising edges are found from the synchronized samples. Neither count input carries a valid/ready handshake. They are plain level pins, and the other control and status pins are plain as well. The block cannot apply back-pressure, and an edge that the block has no use for is dropped.

Two further controls act on the system clock. An active-high clear forces the digit to zero. An active-low load copies a 4-bit data word into the digit, and the word is stored unchanged even when it is greater than 9. Clear wins over load, and load wins over counting. Two active-low terminal outputs let digits be chained. The carry output repeats the synchronized up input while the digit is 9. The borrow output repeats the synchronized down input while the digit is 0. Either output can therefore drive the matching count input of the next higher digit.

Top module: `bcd_updown_digit`

## Requirements
- R1: While rst_n is low, value is 0 and carry_n and borrow_n are 1. The count input synchronizers reset to the high level, so releasing reset creates no count edge.
- R2: A low-to-high change on cnt_up increments value by one. The new value appears at the third rising clk edge after the input changes.
- R3: A low-to-high change on cnt_dn decrements value by one, with the same latency as R2.
- R4: Counting up from 9 gives 0, and counting down from 0 gives 9.
- R5: When clr is 1 at a clk edge, value becomes 0 at that edge, whatever load_n, din and the count inputs are doing.
- R6: When clr is 0 and load_n is 0 at a clk edge, value takes din at that edge, whatever the count inputs are doing.
- R7: A count edge detected while clr is 1 or load_n is 0 is discarded. A count input held low through a clear or load is counted on its next rise after the release.
- R8: carry_n is 0 exactly when value is 9 and the synchronized cnt_up level is 0. Otherwise carry_n is 1.
- R9: borrow_n is 0 exactly when value is 0 and the synchronized cnt_dn level is 0. Otherwise borrow_n is 1.
- R10: A loaded value above 9 is held as given. The next count edge, in either direction, sets value to 0.
- R11: If rising edges on cnt_up and cnt_dn are detected in the same clk cycle, value does not change.
- R12: A count input that stays at a constant level, high or low, does not change value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clear to zero, active high, sampled on clk |
| load_n | input | 1 | Parallel load, active low, sampled on clk |
| din | input | 4 | Data word copied in by load |
| cnt_up | input | 1 | Up-count input, asynchronous, counts on rising edges |
| cnt_dn | input | 1 | Down-count input, asynchronous, counts on rising edges |
| value | output | 4 | Current digit |
| carry_n | output | 1 | Terminal count for counting up, active low |
| borrow_n | output | 1 | Terminal count for counting down, active low |

## Verification
The bench builds the block with its default parameters: a 4-bit digit, a top value of 9 and a two-stage synchronizer. With these values the two wrap points and the above-range loads 12 and 15 can all be reached in a few steps. The two-stage synchronizer fixes the latency of a count edge at three clock edges, and every check waits long enough to cover it. Directed cases then check that the terminal outputs repeat the count inputs at 9 and at 0, that edges arriving during a clear or load are discarded, that an input held low through a clear is counted afterwards, and that simultaneous rises on both count inputs leave the value unchanged.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_INC  = 2'd1,
    STEP_DEC  = 2'd2
  } step_e;
endpackage

// File: rtl/bcd_edge_sense.sv
module bcd_edge_sense #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic lvl_sync,
  output logic rise
);
  // chain[STAGES-1] is the synchronized level; chain[STAGES] holds its previous value
  logic [STAGES:0] chain;

  genvar i;
  generate
    for (i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= pin_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign lvl_sync = chain[STAGES-1];
  assign rise     = chain[STAGES-1] & ~chain[STAGES];
endmodule

// File: rtl/bcd_digit_core.sv
module bcd_digit_core
  import bcd_digit_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int MAX_VAL = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] din,
  input  logic               up_rise,
  input  logic               dn_rise,
  output logic [DIGIT_W-1:0] value
);
  localparam logic [DIGIT_W-1:0] TOP  = DIGIT_W'(MAX_VAL);
  localparam logic [DIGIT_W-1:0] ZERO = '0;
  localparam logic [DIGIT_W-1:0] ONE  = DIGIT_W'(1);

  step_e              step;
  logic [DIGIT_W-1:0] stepped;

  always_comb begin
    if (up_rise && !dn_rise)      step = STEP_INC;
    else if (dn_rise && !up_rise) step = STEP_DEC;
    else                          step = STEP_HOLD;
  end

  always_comb begin
    stepped = value;
    if (value > TOP) begin
      // an out-of-range word only ever leaves through zero
      if (step != STEP_HOLD) stepped = ZERO;
    end else begin
      case (step)
        STEP_INC: stepped = (value == TOP)  ? ZERO : value + ONE;
        STEP_DEC: stepped = (value == ZERO) ? TOP  : value - ONE;
        default:  stepped = value;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= ZERO;
    else if (clr)     value <= ZERO;
    else if (!load_n) value <= din;
    else              value <= stepped;
  end
endmodule

// File: rtl/bcd_term_count.sv
module bcd_term_count #(
  parameter int DIGIT_W = 4,
  parameter int MAX_VAL = 9
) (
  input  logic [DIGIT_W-1:0] value,
  input  logic               up_lvl,
  input  logic               dn_lvl,
  output logic               carry_n,
  output logic               borrow_n
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(MAX_VAL);

  assign carry_n  = ~((value == TOP) & ~up_lvl);
  assign borrow_n = ~((value == '0)  & ~dn_lvl);
endmodule

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit #(
  parameter int DIGIT_W     = 4,
  parameter int MAX_VAL     = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] din,
  input  logic               cnt_up,
  input  logic               cnt_dn,
  output logic [DIGIT_W-1:0] value,
  output logic               carry_n,
  output logic               borrow_n
);
  logic up_lvl, up_rise, dn_lvl, dn_rise;

  bcd_edge_sense #(.STAGES(SYNC_STAGES)) up_sense_i (
    .clk(clk), .rst_n(rst_n), .pin_async(cnt_up), .lvl_sync(up_lvl), .rise(up_rise)
  );

  bcd_edge_sense #(.STAGES(SYNC_STAGES)) dn_sense_i (
    .clk(clk), .rst_n(rst_n), .pin_async(cnt_dn), .lvl_sync(dn_lvl), .rise(dn_rise)
  );

  bcd_digit_core #(.DIGIT_W(DIGIT_W), .MAX_VAL(MAX_VAL)) core_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .up_rise(up_rise), .dn_rise(dn_rise), .value(value)
  );

  bcd_term_count #(.DIGIT_W(DIGIT_W), .MAX_VAL(MAX_VAL)) term_i (
    .value(value), .up_lvl(up_lvl), .dn_lvl(dn_lvl),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );
endmodule

// File: rtl/bcd_updown_digit_chk.sv
module bcd_updown_digit_chk #(
  parameter int DIGIT_W = 4,
  parameter int MAX_VAL = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clr,
  input logic               load_n,
  input logic [DIGIT_W-1:0] din,
  input logic [DIGIT_W-1:0] value,
  input logic               carry_n,
  input logic               borrow_n
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(MAX_VAL);

  logic               armed;
  logic [DIGIT_W-1:0] prev_val;
  logic               prev_ctl;
  logic               legal_move;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      prev_val <= '0;
      prev_ctl <= 1'b0;
    end else begin
      armed    <= 1'b1;
      prev_val <= value;
      prev_ctl <= clr | ~load_n;
    end
  end

  assign legal_move = (value == '0) || (value == TOP) ||
                      (value == prev_val + DIGIT_W'(1)) ||
                      (value == prev_val - DIGIT_W'(1));

  // R5: clear forces zero at the next edge
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (value == '0));

  // R6: load copies din when clear is idle
  a_r6_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (value == $past(din)));

  // R8: carry only at the top value
  a_r8_carry_top: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (value == TOP));

  // R9: borrow only at zero
  a_r9_borrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (value == '0));

  // R2: without clear or load, a change is a single step, a wrap or an exit to zero
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !prev_ctl && (value != prev_val)) |-> legal_move);
endmodule

bind bcd_updown_digit bcd_updown_digit_chk #(.DIGIT_W(DIGIT_W), .MAX_VAL(MAX_VAL)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
  .value(value), .carry_n(carry_n), .borrow_n(borrow_n)
);

// File: tb/bcd_updown_digit_tb_top.sv
`timescale 1ns/1ps
module bcd_updown_digit_tb_top;
  localparam int NVEC = 18;
  localparam logic [3:0] OP_UP = 4'd1, OP_DN = 4'd2, OP_LD = 4'd3, OP_CL = 4'd4;
  // each entry: {op, din, expected value}
  localparam logic [11:0] VECS [NVEC] = '{
    {OP_UP, 4'd0,  4'd1}, {OP_UP, 4'd0,  4'd2}, {OP_DN, 4'd0,  4'd1},
    {OP_DN, 4'd0,  4'd0}, {OP_DN, 4'd0,  4'd9}, {OP_UP, 4'd0,  4'd0},
    {OP_LD, 4'd7,  4'd7}, {OP_UP, 4'd0,  4'd8}, {OP_UP, 4'd0,  4'd9},
    {OP_UP, 4'd0,  4'd0}, {OP_LD, 4'd3,  4'd3}, {OP_CL, 4'd0,  4'd0},
    {OP_LD, 4'd12, 4'd12},{OP_UP, 4'd0,  4'd0}, {OP_LD, 4'd15, 4'd15},
    {OP_DN, 4'd0,  4'd0}, {OP_LD, 4'd9,  4'd9}, {OP_DN, 4'd0,  4'd8}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       cnt_up = 1'b1;
  logic       cnt_dn = 1'b1;
  logic [3:0] value;
  logic       carry_n, borrow_n;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bcd_updown_digit dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .value(value),
    .carry_n(carry_n), .borrow_n(borrow_n)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_up();
    cnt_up = 1'b0; idle(4); cnt_up = 1'b1; idle(4);
  endtask

  task automatic pulse_dn();
    cnt_dn = 1'b0; idle(4); cnt_dn = 1'b1; idle(4);
  endtask

  task automatic do_load(input logic [3:0] d);
    din = d; load_n = 1'b0; idle(2); load_n = 1'b1; idle(2);
  endtask

  task automatic do_clear();
    clr = 1'b1; idle(2); clr = 1'b0; idle(2);
  endtask

  initial begin
    idle(3);
    // R1: reset state
    check("R1", value, 4'd0);
    check("R1", {3'd0, carry_n}, 4'd1);
    check("R1", {3'd0, borrow_n}, 4'd1);
    rst_n = 1'b1;
    idle(4);
    check("R1", value, 4'd0);

    // R2: exact latency, third rising edge after the change
    cnt_up = 1'b0; idle(4);
    cnt_up = 1'b1;
    idle(2);
    check("R2", value, 4'd0);
    idle(1);
    check("R2", value, 4'd1);
    idle(2);
    do_clear();

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] op, d, e;
      {op, d, e} = VECS[v];
      case (op)
        OP_UP: begin pulse_up(); check((e == 4'd0) ? "R4/R10 up" : "R2 up", value, e); end
        OP_DN: begin pulse_dn(); check((e == 4'd9) ? "R4 down" : "R3 down", value, e); end
        OP_LD: begin do_load(d); check("R6 load", value, e); end
        default: begin do_clear(); check("R5 clear", value, e); end
      endcase
    end

    // R8: carry repeats up input at 9
    do_load(4'd9);
    check("R8", {3'd0, carry_n}, 4'd1);
    cnt_up = 1'b0; idle(4);
    check("R8", {3'd0, carry_n}, 4'd0);
    cnt_up = 1'b1; idle(4);
    check("R8", value, 4'd0);
    check("R8", {3'd0, carry_n}, 4'd1);

    // R9: borrow repeats down input at 0
    cnt_dn = 1'b0; idle(4);
    check("R9", {3'd0, borrow_n}, 4'd0);
    cnt_dn = 1'b1; idle(4);
    check("R9", value, 4'd9);
    check("R9", {3'd0, borrow_n}, 4'd1);

    // R7: edge during load discarded
    din = 4'd5; load_n = 1'b0;
    cnt_up = 1'b0; idle(4); cnt_up = 1'b1; idle(4);
    load_n = 1'b1; idle(4);
    check("R7 load", value, 4'd5);
    // R5: clear beats load and count edges
    din = 4'd6; load_n = 1'b0; clr = 1'b1;
    cnt_dn = 1'b0; idle(4); cnt_dn = 1'b1; idle(4);
    clr = 1'b0; load_n = 1'b1; idle(4);
    check("R5 priority", value, 4'd0);
    // R7: input low through clear counts on its rise afterwards
    cnt_up = 1'b0; idle(2);
    clr = 1'b1; idle(3); clr = 1'b0; idle(2);
    cnt_up = 1'b1; idle(4);
    check("R7 held low", value, 4'd1);

    // R11: simultaneous rises hold value
    do_load(4'd4);
    cnt_up = 1'b0; cnt_dn = 1'b0; idle(4);
    cnt_up = 1'b1; cnt_dn = 1'b1; idle(4);
    check("R11", value, 4'd4);

    // R12: constant levels do nothing
    idle(10);
    check("R12 high", value, 4'd4);
    cnt_up = 1'b0; idle(10);
    check("R12 low", value, 4'd4);
    cnt_up = 1'b1; idle(4);
    check("R12 then edge", value, 4'd5);

    // R10: out-of-range word held until a count edge
    do_load(4'd11);
    idle(6);
    check("R10 hold", value, 4'd11);
    pulse_dn();
    check("R10 exit", value, 4'd0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule